// File: doc/BRIEF.md
# Cascaded Alpha Blend Compositor

This block merges up to four image layers over a constant background colour and emits one raster-ordered stream of output pixels. The layers are blended by a chain of stages. The first stage takes a synthetic background pixel as its destination: the programmed colour with opaque alpha, covering the whole frame. Each later stage takes the result of the stage before it as its destination. Layer 0 is blended first, at the bottom, and the highest-numbered layer is blended last, on top. Each layer can be switched on or off, can be marked as carrying premultiplied colour, and is placed at a top-left offset inside the output frame.

The block generates the output raster itself. For every output position it works out which layers cover that position and pulls one pixel from each of those layer streams, using a valid/ready handshake. A layer supplies only the part of itself that lies inside the frame, in raster order. The frame and layer configuration is sampled once at the start of each frame, so software can change it while a frame is still running.

A layer's stage acts as a pass-through wherever that layer is off or does not cover the current position. Each stage takes two cycles. The end-of-line and end-of-frame flags travel with the pixel through the stages. Backpressure on the output freezes the whole pipeline.

Top module: `layer_compositor`

## Requirements
- R1: A pixel is 32 bits: alpha in bits 31:24 and three colour components in bits 23:16, 15:8 and 7:0. The bottom stage's destination is {0xFF, bg_color}. With no layer covering a position, the output at that position is exactly that value.
- R2: For a straight-alpha layer, each colour component becomes sat(m(D, 255-Sa) + m(S, Sa)). Here m(a,b) = (a*b+127)/255 with integer division, and sat limits the sum to 255.
- R3: For a layer whose premultiplied bit is set, each colour component becomes sat(m(D, 255-Sa) + S); the source colour is not scaled.
- R4: In both modes the alpha becomes sat(m(Da, 255-Sa) + Sa). Because the background is opaque, every output pixel therefore has alpha 0xFF.
- R5: A disabled layer is never offered ready, its data is ignored, and its stage passes the destination through unchanged.
- R6: Layers are blended in index order, so layer 0 lies at the bottom and layer N-1 on top.
- R7: Layer pixel (c,r) lands at output position (x+c, y+r), where (x,y) is the layer's offset. Outside the layer's rectangle its stage passes the destination through. The layer stream supplies only the visible part of the layer, in raster order, clipped at the right and bottom frame edges. A layer of width or height 0 covers nothing.
- R8: A layer's x offset is clamped to at most width-1, and its y offset to at most height-1.
- R9: Frame width and height are clamped to the range 1 to MAX_DIM (8190 by default). A value of 0 acts as 1.
- R10: Output pixels come in raster order. out_eol marks the last column of each line, and out_eof marks the last pixel of the frame.
- R11: While out_valid is high and out_ready is low, the output pixel and its flags hold steady; no pixel is lost or duplicated. During reset, out_valid and every lay_ready are low.
- R12: All configuration inputs are captured at the start of each frame. A change during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_w | input | DW | Output frame width in pixels |
| frame_h | input | DW | Output frame height in lines |
| bg_color | input | 24 | Background colour components |
| lay_en | input | N | Per-layer enable |
| lay_premul | input | N | Per-layer premultiplied-colour flag |
| lay_x | input | N x DW | Per-layer left offset |
| lay_y | input | N x DW | Per-layer top offset |
| lay_w | input | N x DW | Per-layer width |
| lay_h | input | N x DW | Per-layer height |
| lay_valid | input | N | Per-layer pixel valid |
| lay_ready | output | N | Per-layer pixel accepted |
| lay_data | input | N x 32 | Per-layer pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted downstream |
| out_data | output | 32 | Composited pixel |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The hardest case to reach from the ports is a configuration change that lands while pixels of the previous frame are still inside the stages. Output backpressure and gaps in the layer streams must run at the same time, so that old and new settings coexist in the pipeline. The stimulus rewrites every configuration input as soon as the first pixel of a frame appears at the output. Frames are kept long enough that this always happens mid-frame, and random ready and valid gaps are applied throughout. A further case, a layer clipped at the far right of a maximum-width line, is driven with a single line of the largest frame width.

// File: rtl/comp_pkg.sv
`timescale 1ns/1ps
package comp_pkg;
   localparam int PIX_W = 32;
   localparam int CH_W  = 8;

   typedef logic [PIX_W-1:0] pix_t;

   // a*b/255 rounded to nearest
   function automatic logic [CH_W-1:0] frac_mul(input logic [CH_W-1:0] a,
                                                input logic [CH_W-1:0] b);
      logic [15:0] p;
      p = 16'(a) * 16'(b) + 16'd127;
      return CH_W'(p / 16'd255);
   endfunction

   function automatic logic [CH_W-1:0] sat_add(input logic [CH_W-1:0] a,
                                               input logic [CH_W-1:0] b);
      logic [CH_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[CH_W] ? {CH_W{1'b1}} : s[CH_W-1:0];
   endfunction
endpackage

// File: rtl/comp_raster.sv
`timescale 1ns/1ps
module comp_raster import comp_pkg::*; #(
   parameter int N       = 4,
   parameter int MAX_DIM = 8190,
   parameter int DW      = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic [DW-1:0]       cfg_w,
   input  logic [DW-1:0]       cfg_h,
   input  logic [23:0]         cfg_bg,
   input  logic [N-1:0]        cfg_en,
   input  logic [N-1:0]        cfg_pm,
   input  logic [N-1:0][DW-1:0] cfg_x,
   input  logic [N-1:0][DW-1:0] cfg_y,
   input  logic [N-1:0][DW-1:0] cfg_lw,
   input  logic [N-1:0][DW-1:0] cfg_lh,
   input  logic [N-1:0]        lay_valid,
   input  logic [N-1:0][31:0]  lay_data,
   output logic [N-1:0]        lay_ready,
   output logic [N-1:0]        en_q,
   output logic                iss_vld,
   output pix_t                iss_dst,
   output logic [N-1:0][31:0]  iss_src,
   output logic [N-1:0]        iss_act,
   output logic [N-1:0]        iss_pm,
   output logic                iss_eol,
   output logic                iss_eof
);
   localparam logic [DW-1:0] DIM_HI = DW'(MAX_DIM);

   function automatic logic [DW-1:0] clamp_dim(input logic [DW-1:0] v);
      if (v == '0)    return DW'(1);
      if (v > DIM_HI) return DIM_HI;
      return v;
   endfunction

   logic                 load_pend;
   logic [DW-1:0]        fw_q, fh_q, x_cnt, y_cnt;
   logic [23:0]          bg_q;
   logic [N-1:0]         pm_q;
   logic [N-1:0][DW-1:0] ox_q, oy_q, lw_q, lh_q;

   logic [DW-1:0]        fw_n, fh_n;
   logic [N-1:0][DW-1:0] ox_n, oy_n;
   logic [N-1:0]         req;
   logic                 eol, eof, issue;

   assign fw_n = clamp_dim(cfg_w);
   assign fh_n = clamp_dim(cfg_h);

   for (genvar i = 0; i < N; i++) begin : g_lay
      assign ox_n[i] = (cfg_x[i] > fw_n - 1'b1) ? fw_n - 1'b1 : cfg_x[i];
      assign oy_n[i] = (cfg_y[i] > fh_n - 1'b1) ? fh_n - 1'b1 : cfg_y[i];
      assign req[i]  = en_q[i]
                     && (x_cnt >= ox_q[i]) && ((x_cnt - ox_q[i]) < lw_q[i])
                     && (y_cnt >= oy_q[i]) && ((y_cnt - oy_q[i]) < lh_q[i]);
   end

   assign eol       = (x_cnt == fw_q - 1'b1);
   assign eof       = eol && (y_cnt == fh_q - 1'b1);
   assign issue     = !load_pend && adv && ((req & ~lay_valid) == '0);
   assign lay_ready = issue ? req : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_pend <= 1'b1;
         x_cnt     <= '0;
         y_cnt     <= '0;
         fw_q      <= DW'(1);
         fh_q      <= DW'(1);
         bg_q      <= '0;
         en_q      <= '0;
         pm_q      <= '0;
         ox_q      <= '0;
         oy_q      <= '0;
         lw_q      <= '0;
         lh_q      <= '0;
      end else if (load_pend) begin
         load_pend <= 1'b0;
         x_cnt     <= '0;
         y_cnt     <= '0;
         fw_q      <= fw_n;
         fh_q      <= fh_n;
         bg_q      <= cfg_bg;
         en_q      <= cfg_en;
         pm_q      <= cfg_pm;
         ox_q      <= ox_n;
         oy_q      <= oy_n;
         lw_q      <= cfg_lw;
         lh_q      <= cfg_lh;
      end else if (issue) begin
         if (eol) begin
            x_cnt <= '0;
            if (eof) begin
               y_cnt     <= '0;
               load_pend <= 1'b1;
            end else begin
               y_cnt <= y_cnt + 1'b1;
            end
         end else begin
            x_cnt <= x_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_vld <= 1'b0;
         iss_dst <= '0;
         iss_src <= '0;
         iss_act <= '0;
         iss_pm  <= '0;
         iss_eol <= 1'b0;
         iss_eof <= 1'b0;
      end else if (adv) begin
         iss_vld <= issue;
         iss_dst <= {8'hFF, bg_q};
         iss_src <= lay_data;
         iss_act <= req;
         iss_pm  <= pm_q;
         iss_eol <= eol;
         iss_eof <= eof;
      end
   end
endmodule

// File: rtl/comp_delay.sv
`timescale 1ns/1ps
module comp_delay #(
   parameter int WIDTH = 34,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_shift
      logic [DEPTH-1:0][WIDTH-1:0] sr;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sr <= '0;
         end else if (en) begin
            sr[0] <= d;
            for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
         end
      end
      assign q = sr[DEPTH-1];
   end
endmodule

// File: rtl/comp_blend_stage.sv
`timescale 1ns/1ps
module comp_blend_stage import comp_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        in_vld,
   input  pix_t        in_dst,
   input  pix_t        in_src,
   input  logic        in_act,
   input  logic        in_pm,
   input  logic        in_eol,
   input  logic        in_eof,
   output logic        out_vld,
   output pix_t        out_dst,
   output logic        out_eol,
   output logic        out_eof
);
   logic            v1, act1, eol1, eof1;
   pix_t            dst1;
   logic [7:0]      sa1, pa1;
   logic [2:0][7:0] pd1, ps1;
   logic [7:0]      sa, inv;

   assign sa  = in_src[31:24];
   assign inv = ~sa;

   // cycle 1: products
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1   <= 1'b0;
         act1 <= 1'b0;
         eol1 <= 1'b0;
         eof1 <= 1'b0;
         dst1 <= '0;
         sa1  <= '0;
         pa1  <= '0;
         pd1  <= '0;
         ps1  <= '0;
      end else if (en) begin
         v1   <= in_vld;
         act1 <= in_act;
         eol1 <= in_eol;
         eof1 <= in_eof;
         dst1 <= in_dst;
         sa1  <= sa;
         pa1  <= frac_mul(in_dst[31:24], inv);
         for (int c = 0; c < 3; c++) begin
            pd1[c] <= frac_mul(in_dst[c*8 +: 8], inv);
            ps1[c] <= in_pm ? in_src[c*8 +: 8] : frac_mul(in_src[c*8 +: 8], sa);
         end
      end
   end

   // cycle 2: sums or pass-through
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dst <= '0;
         out_eol <= 1'b0;
         out_eof <= 1'b0;
      end else if (en) begin
         out_vld <= v1;
         out_eol <= eol1;
         out_eof <= eof1;
         if (act1) begin
            out_dst[31:24] <= sat_add(pa1, sa1);
            for (int c = 0; c < 3; c++) out_dst[c*8 +: 8] <= sat_add(pd1[c], ps1[c]);
         end else begin
            out_dst <= dst1;
         end
      end
   end
endmodule

// File: rtl/layer_compositor.sv
`timescale 1ns/1ps
module layer_compositor import comp_pkg::*; #(
   parameter int N       = 4,
   parameter int MAX_DIM = 8190,
   localparam int DW     = $clog2(MAX_DIM + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DW-1:0]        frame_w,
   input  logic [DW-1:0]        frame_h,
   input  logic [23:0]          bg_color,
   input  logic [N-1:0]         lay_en,
   input  logic [N-1:0]         lay_premul,
   input  logic [N-1:0][DW-1:0] lay_x,
   input  logic [N-1:0][DW-1:0] lay_y,
   input  logic [N-1:0][DW-1:0] lay_w,
   input  logic [N-1:0][DW-1:0] lay_h,
   input  logic [N-1:0]         lay_valid,
   output logic [N-1:0]         lay_ready,
   input  logic [N-1:0][31:0]   lay_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [31:0]          out_data,
   output logic                 out_eol,
   output logic                 out_eof
);
   localparam int SB_W = PIX_W + 2;

   if (N < 1 || N > 8) begin : g_bad_n
      $error("layer_compositor: N must be 1..8");
   end
   if (MAX_DIM < 1) begin : g_bad_dim
      $error("layer_compositor: MAX_DIM must be positive");
   end

   logic                adv;
   logic [N-1:0]        lay_en_q;
   logic [N:0]          ch_vld, ch_eol, ch_eof;
   pix_t                ch_dst [N+1];
   logic [N-1:0][31:0]  iss_src;
   logic [N-1:0]        iss_act, iss_pm;

   assign adv = !out_valid || out_ready;

   comp_raster #(.N(N), .MAX_DIM(MAX_DIM), .DW(DW)) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .cfg_w    (frame_w),
      .cfg_h    (frame_h),
      .cfg_bg   (bg_color),
      .cfg_en   (lay_en),
      .cfg_pm   (lay_premul),
      .cfg_x    (lay_x),
      .cfg_y    (lay_y),
      .cfg_lw   (lay_w),
      .cfg_lh   (lay_h),
      .lay_valid(lay_valid),
      .lay_data (lay_data),
      .lay_ready(lay_ready),
      .en_q     (lay_en_q),
      .iss_vld  (ch_vld[0]),
      .iss_dst  (ch_dst[0]),
      .iss_src  (iss_src),
      .iss_act  (iss_act),
      .iss_pm   (iss_pm),
      .iss_eol  (ch_eol[0]),
      .iss_eof  (ch_eof[0])
   );

   for (genvar i = 0; i < N; i++) begin : g_stage
      logic [SB_W-1:0] sb;

      comp_delay #(.WIDTH(SB_W), .DEPTH(2*i)) u_dly (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (adv),
         .d    ({iss_act[i], iss_pm[i], iss_src[i]}),
         .q    (sb)
      );

      comp_blend_stage u_blend (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (adv),
         .in_vld (ch_vld[i]),
         .in_dst (ch_dst[i]),
         .in_src (sb[PIX_W-1:0]),
         .in_act (sb[PIX_W+1]),
         .in_pm  (sb[PIX_W]),
         .in_eol (ch_eol[i]),
         .in_eof (ch_eof[i]),
         .out_vld(ch_vld[i+1]),
         .out_dst(ch_dst[i+1]),
         .out_eol(ch_eol[i+1]),
         .out_eof(ch_eof[i+1])
      );
   end

   assign out_valid = ch_vld[N];
   assign out_data  = ch_dst[N];
   assign out_eol   = ch_eol[N];
   assign out_eof   = ch_eof[N];
endmodule

// File: rtl/comp_checker.sv
`timescale 1ns/1ps
module comp_checker #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         out_valid,
   input logic         out_ready,
   input logic [31:0]  out_data,
   input logic         out_eol,
   input logic         out_eof,
   input logic [N-1:0] lay_valid,
   input logic [N-1:0] lay_ready,
   input logic [N-1:0] lay_en_q
);
   // R4
   opaque_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data[31:24] == 8'hFF);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_eol) && $stable(out_eof)));

   // R10
   eof_on_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_eof) |-> out_eol);

   // R5
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lay_ready & ~lay_en_q) == '0);

   // R7
   ready_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lay_ready & ~lay_valid) == '0);
endmodule

bind layer_compositor comp_checker #(.N(N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_eol  (out_eol),
   .out_eof  (out_eof),
   .lay_valid(lay_valid),
   .lay_ready(lay_ready),
   .lay_en_q (lay_en_q)
);

// File: tb/sim_layer_compositor.sv
`timescale 1ns/1ps
module sim_layer_compositor;
   localparam int N  = 4;
   localparam int MD = 8190;
   localparam int DW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] frame_w, frame_h;
   logic [23:0] bg_color;
   logic [N-1:0] lay_en, lay_premul, lay_valid, lay_ready;
   logic [N-1:0][DW-1:0] lay_x, lay_y, lay_w, lay_h;
   logic [N-1:0][31:0] lay_data;
   logic out_valid, out_ready, out_eol, out_eof;
   logic [31:0] out_data;

   always #10 clk = ~clk;

   layer_compositor #(.N(N), .MAX_DIM(MD)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
      .bg_color(bg_color), .lay_en(lay_en), .lay_premul(lay_premul),
      .lay_x(lay_x), .lay_y(lay_y), .lay_w(lay_w), .lay_h(lay_h),
      .lay_valid(lay_valid), .lay_ready(lay_ready), .lay_data(lay_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_eol(out_eol), .out_eof(out_eof));

   int checks = 0;
   int fails  = 0;

   // per-frame configuration (two frames per scenario)
   int c_fw[2], c_fh[2];
   logic [23:0] c_bg[2];
   logic [N-1:0] c_en[2], c_pm[2];
   int c_x[2][N], c_y[2][N], c_lw[2][N], c_lh[2][N];
   int scn;
   int rdy_pct, gap_pct;
   bit seen_first, mon_done;

   function automatic int eff_dim(input int v);
      if (v == 0) return 1;
      if (v > MD) return MD;
      return v;
   endfunction

   function automatic int eff_off(input int o, input int d);
      return (o > d - 1) ? d - 1 : o;
   endfunction

   function automatic logic [31:0] src_pix(input int s, input int f, input int li,
                                           input int c, input int r);
      logic [31:0] h;
      logic [7:0] a;
      h = 32'(s * 7919 + f * 104729 + li * 1299709 + c * 31 + r * 8191);
      h = h * 32'd1103515245 + 32'd12345;
      h = h ^ (h >> 13);
      h = h * 32'd2654435761;
      case (h[1:0])
         2'd0: a = 8'h00;
         2'd1: a = 8'hFF;
         default: a = h[31:24];
      endcase
      return {a, h[27:4]};
   endfunction

   function automatic logic [31:0] blend_ref(input logic [31:0] d, input logic [31:0] s,
                                             input bit pm);
      int sa, inv, t;
      logic [31:0] o;
      sa  = int'(s[31:24]);
      inv = 255 - sa;
      t = (int'(d[31:24]) * inv + 127) / 255 + sa;
      o[31:24] = 8'((t > 255) ? 255 : t);
      for (int c = 0; c < 3; c++) begin
         t = (int'(d[c*8 +: 8]) * inv + 127) / 255
           + (pm ? int'(s[c*8 +: 8]) : (int'(s[c*8 +: 8]) * sa + 127) / 255);
         o[c*8 +: 8] = 8'((t > 255) ? 255 : t);
      end
      return o;
   endfunction

   function automatic logic [31:0] exp_pix(input int f, input int x, input int y,
                                           output bit any_pm, output bit any_cov);
      logic [31:0] d;
      int fw, fh, ox, oy;
      fw = eff_dim(c_fw[f]);
      fh = eff_dim(c_fh[f]);
      d  = {8'hFF, c_bg[f]};
      any_pm = 0;
      any_cov = 0;
      for (int i = 0; i < N; i++) begin
         ox = eff_off(c_x[f][i], fw);
         oy = eff_off(c_y[f][i], fh);
         if (c_en[f][i] && x >= ox && x - ox < c_lw[f][i] && y >= oy && y - oy < c_lh[f][i]) begin
            any_cov = 1;
            if (c_pm[f][i]) any_pm = 1;
            d = blend_ref(d, src_pix(scn, f, i, x - ox, y - oy), c_pm[f][i]);
         end
      end
      return d;
   endfunction

   task automatic apply_cfg(input int f);
      frame_w  = DW'(c_fw[f]);
      frame_h  = DW'(c_fh[f]);
      bg_color = c_bg[f];
      lay_en   = c_en[f];
      lay_premul = c_pm[f];
      for (int i = 0; i < N; i++) begin
         lay_x[i] = DW'(c_x[f][i]);
         lay_y[i] = DW'(c_y[f][i]);
         lay_w[i] = DW'(c_lw[f][i]);
         lay_h[i] = DW'(c_lh[f][i]);
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic drive_layer(input int li, input int nfr);
      for (int f = 0; f < nfr; f++) begin
         int fw, fh, ox, oy, vw, vh;
         fw = eff_dim(c_fw[f]);
         fh = eff_dim(c_fh[f]);
         ox = eff_off(c_x[f][li], fw);
         oy = eff_off(c_y[f][li], fh);
         vw = (c_lw[f][li] < fw - ox) ? c_lw[f][li] : fw - ox;
         vh = (c_lh[f][li] < fh - oy) ? c_lh[f][li] : fh - oy;
         if (!c_en[f][li]) begin
            if (f == nfr - 1) begin
               // R5: garbage offered on a disabled layer must never be taken
               int hits = 0;
               lay_valid[li] = 1'b1;
               lay_data[li]  = 32'hDEAD_BEE0 | 32'(li);
               while (!mon_done) begin
                  @(negedge clk);
                  #8;
                  if (lay_ready[li]) hits++;
               end
               lay_valid[li] = 1'b0;
               check(hits == 0, "R5", "ready on disabled layer", 32'(hits), 32'd0);
            end
            continue;
         end
         for (int r = 0; r < vh; r++) begin
            for (int c = 0; c < vw; c++) begin
               bit tk;
               while (($urandom % 100) < gap_pct) @(negedge clk);
               lay_valid[li] = 1'b1;
               lay_data[li]  = src_pix(scn, f, li, c, r);
               do begin
                  #8;
                  tk = lay_ready[li];
                  @(negedge clk);
               end while (!tk);
               lay_valid[li] = 1'b0;
            end
         end
      end
   endtask

   task automatic monitor(input int nfr, input string tag);
      bit pend = 0;
      logic [31:0] held;
      for (int f = 0; f < nfr; f++) begin
         int fw, fh;
         fw = eff_dim(c_fw[f]);
         fh = eff_dim(c_fh[f]);
         for (int y = 0; y < fh; y++) begin
            for (int x = 0; x < fw; x++) begin
               logic [31:0] e;
               bit apm, acov;
               string rq;
               forever begin
                  @(negedge clk);
                  out_ready = (($urandom % 100) < rdy_pct);
                  #8;
                  if (pend) begin
                     // R11: stalled output holds its value
                     check(out_valid && out_data == held, "R11", "stall hold", out_data, held);
                     pend = 0;
                  end
                  if (out_valid && !out_ready) begin
                     pend = 1;
                     held = out_data;
                  end
                  if (out_valid && out_ready) break;
               end
               e = exp_pix(f, x, y, apm, acov);
               rq = !acov ? "R1" : (apm ? "R3" : "R2");
               // R4 alpha, R6 order, R7 placement, R8/R9 clamps, R12 capture
               check(out_data == e, rq, $sformatf("%s f%0d (%0d,%0d)", tag, f, x, y),
                     out_data, e);
               // R10: sideband flags
               check(out_eol == (x == fw - 1) && out_eof == (x == fw - 1 && y == fh - 1),
                     "R10", $sformatf("%s eol/eof (%0d,%0d)", tag, x, y),
                     {30'd0, out_eol, out_eof},
                     {30'd0, 1'(x == fw - 1), 1'(x == fw - 1 && y == fh - 1)});
               if (f == 0) seen_first = 1;
            end
         end
      end
      out_ready = 1'b0;
      mon_done = 1;
   endtask

   task automatic run_scn(input int nfr, input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      lay_valid = '0;
      lay_data = '0;
      out_ready = 1'b0;
      apply_cfg(0);
      repeat (3) @(negedge clk);
      #8;
      // R11: idle outputs during reset
      check(out_valid == 1'b0 && lay_ready == '0, "R11", "reset state",
            {27'd0, out_valid, lay_ready}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      seen_first = 0;
      mon_done = 0;
      fork
         monitor(nfr, tag);
         drive_layer(0, nfr);
         drive_layer(1, nfr);
         drive_layer(2, nfr);
         drive_layer(3, nfr);
         begin
            if (nfr > 1) begin
               // R12: switch settings mid-frame; they apply to the next frame
               wait (seen_first);
               @(negedge clk);
               apply_cfg(1);
            end
         end
      join
   endtask

   task automatic clear_cfg();
      for (int f = 0; f < 2; f++) begin
         c_fw[f] = 8; c_fh[f] = 4; c_bg[f] = 24'h0; c_en[f] = '0; c_pm[f] = '0;
         for (int i = 0; i < N; i++) begin
            c_x[f][i] = 0; c_y[f][i] = 0; c_lw[f][i] = 0; c_lh[f][i] = 0;
         end
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rdy_pct = 70;
      gap_pct = 25;

      // R9 low clamp, R8 offset clamp: 0x0 frame acts as 1x1
      clear_cfg();
      scn = 1;
      c_fw[0] = 0; c_fh[0] = 0; c_bg[0] = 24'h123456;
      c_en[0] = 4'b1100; c_pm[0] = 4'b0100;
      c_x[0][2] = 7; c_y[0][2] = 3; c_lw[0][2] = 1; c_lh[0][2] = 1;
      c_x[0][3] = 0; c_y[0][3] = 0; c_lw[0][3] = 2; c_lh[0][3] = 2;
      run_scn(1, "tiny");

      // R9 high clamp, R7 right clipping on a maximum-width line
      clear_cfg();
      scn = 2;
      c_fw[0] = 8191; c_fh[0] = 1; c_bg[0] = 24'h00FF80;
      c_en[0] = 4'b0011; c_pm[0] = 4'b0010;
      c_x[0][0] = 8189; c_lw[0][0] = 4; c_lh[0][0] = 1;
      c_x[0][1] = 8191; c_lw[0][1] = 3; c_lh[0][1] = 2;
      rdy_pct = 85; gap_pct = 5;
      run_scn(1, "wide");

      // R6 stacking order: all layers on one spot, straight then premultiplied
      clear_cfg();
      scn = 3;
      for (int f = 0; f < 2; f++) begin
         c_fw[f] = 8; c_fh[f] = 4; c_bg[f] = 24'hA0B0C0; c_en[f] = 4'hF;
         c_pm[f] = (f == 0) ? 4'h0 : 4'hF;
         for (int i = 0; i < N; i++) begin
            c_x[f][i] = 2; c_y[f][i] = 1; c_lw[f][i] = 4; c_lh[f][i] = 2;
         end
      end
      rdy_pct = 60; gap_pct = 30;
      run_scn(2, "stack");

      // R1/R5: all layers off, background only
      clear_cfg();
      scn = 4;
      c_bg[0] = 24'h010203; c_bg[1] = 24'hFEDCBA; c_fw[1] = 5; c_fh[1] = 3;
      run_scn(2, "bg");

      // random scenarios
      for (int s = 0; s < 8; s++) begin
         clear_cfg();
         scn = 10 + s;
         rdy_pct = 40 + int'($urandom % 61);
         gap_pct = int'($urandom % 50);
         for (int f = 0; f < 2; f++) begin
            c_fw[f] = 6 + int'($urandom % 11);
            c_fh[f] = 4 + int'($urandom % 7);
            c_bg[f] = 24'($urandom);
            c_en[f] = 4'($urandom);
            c_pm[f] = 4'($urandom);
            for (int i = 0; i < N; i++) begin
               c_x[f][i]  = int'($urandom % 20);
               c_y[f][i]  = int'($urandom % 14);
               c_lw[f][i] = int'($urandom % 18);
               c_lh[f][i] = int'($urandom % 12);
            end
         end
         run_scn(2, $sformatf("rnd%0d", s));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule